// File: doc/BRIEF.md
# Duty-Cycle Sync Marker Link

This block carries an occasional synchronization marker inside a shared reference clock by changing that clock's duty cycle. It does not use a separate pulse line. The transmitter runs from an oversampling clock at `TICKS` cycles per reference period, ten by default. Ordinary periods are sent with a short high phase. Marked periods are sent with a long high phase. Every period, marked or not, starts with a rising edge at the same phase, so the reference timing never moves.

The receiver takes the incoming line through a synchronizer. It restarts a phase counter on every rising edge and samples the line level halfway through the period, where a short-high period is already low and a long-high period is still high. From those samples it raises a one-cycle sync flag and restarts a local timer, so every receiver on the same line restarts its timer on the same reference period.

Three sending modes are selected by `mode_i`:

- **Single:** a request marks one period.
- **Balanced:** a free-running pattern alternates 50 normal periods with 50 marked periods, and each change between groups is a sync event.
- **Couplet:** one request sends a four-period group with no net low-frequency content.

In a system the transmit line is driven off-chip and the far end's copy arrives on `line_i`. A single instance can loop its own line back.

Top module: `dcsync_link`

## Requirements
- R1: Normal period shape. A normal period lasts `TICKS` cycles. `line_o` is high for ticks 0 to 2 of the period and low for the rest.
- R2: Marked period shape. A marked period is high for ticks 0 to 6 and low for ticks 7 to 9.
- R3: Fixed rising edge. `line_o` rises exactly once per period, at tick 0, so consecutive rising edges are always exactly `TICKS` cycles apart. The first period starts on the first clock edge after reset.
- R4: Receiver timing. The receiver restarts its phase on a rising edge of the synchronized `line_i` and samples the line 5 ticks later. `sync_o` is high for exactly one clock cycle per flagged period. That cycle is `SYNC_STAGES + SAMPLE_TICK + 1` cycles (8 by default) after the first cycle in which `line_i` is high.
- R5: No flag before an edge. After reset, `sync_o` stays low until a rising edge of `line_i` has been seen. In reset, `line_o`, `sync_o` and `timer_o` are 0.
- R6: Single mode (`mode_i` = 0, and also 3). A request pulse on `sync_req_i` during a period, including its last tick, marks the next period. Several requests in one period produce one marked period. In this mode a high mid-period sample raises `sync_o`.
- R7: Balanced mode (`mode_i` = 1). The transmitter repeats 50 normal periods followed by 50 marked periods, starting with normal periods after reset. `sync_req_i` has no effect.
- R8: Balanced mode receiver. `sync_o` is raised when the mid-period sample differs from the previous period's sample, not on its level. The first sample after reset never raises it.
- R9: Couplet mode (`mode_i` = 2). A request sends normal, marked, marked, normal in the next four periods. Other periods are normal. A high mid-period sample raises `sync_o`.
- R10: Busy couplet. A request made while a couplet is pending or being sent, up to and including its fourth period, is ignored.
- R11: Local timer. `timer_o` increments by one every clock cycle, wrapping at its width. It reads 0 in the cycle after each `sync_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, `TICKS` cycles per reference period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 single, 1 balanced, 2 couplet, 3 same as single |
| sync_req_i | input | 1 | Sync request, one cycle or longer |
| line_o | output | 1 | Duty-coded reference line out |
| line_i | input | 1 | Incoming reference line, asynchronous |
| sync_o | output | 1 | Recovered sync flag, one cycle per event |
| timer_o | output | TIMER_W | Local timer, restarted by each sync event |

## Verification
The assertions rely on two assumptions about the inputs:

- `mode_i` changes only while reset is asserted.
- `line_i` is a clean waveform whose rising edges lie more than `SAMPLE_TICK` cycles apart, which any line produced by the transmitter is.

The stimulus respects both. Each mode is entered through a fresh reset, and `line_i` is either the looped-back `line_o` or a bench-driven level held constant over long stretches. Random requests are drawn at densities that cover idle periods, requests on back-to-back periods, and requests that land on a busy couplet.

// File: rtl/dcsync_pkg.sv
package dcsync_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_BALANCED = 2'd1,
    MODE_COUPLET  = 2'd2,
    MODE_ALT      = 2'd3
  } mode_e;

  localparam logic [3:0] COUPLET_PAT = 4'b0110;  // bit 0 is sent first
endpackage

// File: rtl/dcsync_tx.sv
module dcsync_tx
  import dcsync_pkg::*;
#(
  parameter int TICKS     = 10,
  parameter int HI_SHORT  = 3,
  parameter int HI_LONG   = 7,
  parameter int GROUP_LEN = 50
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  req_i,
  output logic  line_o
);
  localparam int TW = $clog2(TICKS);
  localparam int GW = $clog2(GROUP_LEN);
  localparam logic [TW-1:0] TLAST = TW'(TICKS - 1);
  localparam logic [TW-1:0] HS    = TW'(HI_SHORT);
  localparam logic [TW-1:0] HL    = TW'(HI_LONG);
  localparam logic [GW-1:0] GLAST = GW'(GROUP_LEN - 1);

  logic [TW-1:0] tick_q, tick_d;
  logic [GW-1:0] grp_q, grp_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [3:0]    sr_q, sr_d;
  logic          mark_q, mark_d, pend_q, pend_d, phase_q, phase_d, line_q, line_d;
  logic          boundary, is_cpl, busy, accept, load;

  always_comb begin
    boundary = (tick_q == TLAST);
    tick_d   = boundary ? '0 : tick_q + 1'b1;
    is_cpl   = (mode_i == MODE_COUPLET);
    busy     = pend_q | (cnt_q != 3'd0);
    accept   = req_i & ~(is_cpl & busy);
    load     = pend_q | accept;
    mark_d   = mark_q;
    pend_d   = (mode_i == MODE_BALANCED) ? 1'b0 : load;
    cnt_d    = cnt_q;
    sr_d     = sr_q;
    grp_d    = grp_q;
    phase_d  = phase_q;
    if (boundary) begin
      unique case (mode_i)
        MODE_BALANCED: begin
          mark_d = phase_q;
          if (grp_q == GLAST) begin
            grp_d   = '0;
            phase_d = ~phase_q;
          end else begin
            grp_d = grp_q + 1'b1;
          end
        end
        MODE_COUPLET: begin
          if (cnt_q > 3'd1) begin
            mark_d = sr_q[1];
            sr_d   = sr_q >> 1;
            cnt_d  = cnt_q - 3'd1;
          end else if (load) begin
            mark_d = COUPLET_PAT[0];
            sr_d   = COUPLET_PAT;
            cnt_d  = 3'd4;
            pend_d = 1'b0;
          end else begin
            mark_d = 1'b0;
            cnt_d  = 3'd0;
          end
        end
        default: begin
          mark_d = load;
          pend_d = 1'b0;
        end
      endcase
    end
    line_d = tick_d < (mark_d ? HL : HS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= TLAST;
      mark_q  <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= 3'd0;
      sr_q    <= 4'd0;
      grp_q   <= '0;
      phase_q <= 1'b0;
      line_q  <= 1'b0;
    end else begin
      tick_q  <= tick_d;
      mark_q  <= mark_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      sr_q    <= sr_d;
      grp_q   <= grp_d;
      phase_q <= phase_d;
      line_q  <= line_d;
    end
  end

  assign line_o = line_q;

  p_rise_at_tick0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_q) |-> (tick_q == '0));
  p_mark_held_in_period_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q != '0) |-> $stable(mark_q));
  p_no_queue_while_sending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != 3'd0) |-> !pend_q);
endmodule

// File: rtl/dcsync_rx.sv
module dcsync_rx #(
  parameter int TICKS       = 10,
  parameter int SAMPLE_TICK = 5,
  parameter int SYNC_STAGES = 2   // at least 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic balanced_i,
  input  logic line_i,
  output logic flag_o
);
  localparam int PW = $clog2(TICKS);
  localparam logic [PW-1:0] PMAX = PW'(TICKS - 1);
  localparam logic [PW-1:0] PSMP = PW'(SAMPLE_TICK);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [PW-1:0] ph_q, ph_cur;
  logic line_s, prev_q, seen_q, samp_q, samp_vld_q, flag_q;
  logic rise, sample, hit, flag_d;

  always_comb begin
    line_s = sync_q[SYNC_STAGES-1];
    rise   = line_s & ~prev_q;
    ph_cur = rise ? '0 : ((ph_q == PMAX) ? ph_q : ph_q + 1'b1);
    sample = seen_q & ~rise & (ph_cur == PSMP);
    // balanced mode flags on a change between periods, others on level
    hit    = balanced_i ? (samp_vld_q & (line_s ^ samp_q)) : line_s;
    flag_d = sample & hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '0;
      prev_q     <= 1'b0;
      seen_q     <= 1'b0;
      ph_q       <= PMAX;
      samp_q     <= 1'b0;
      samp_vld_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      prev_q <= line_s;
      ph_q   <= ph_cur;
      flag_q <= flag_d;
      if (rise) seen_q <= 1'b1;
      if (sample) begin
        samp_q     <= line_s;
        samp_vld_q <= 1'b1;
      end
    end
  end

  assign flag_o = flag_q;

  p_flag_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> !flag_q);
  p_flag_at_mid_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> (ph_q == PSMP));
  p_no_flag_before_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !flag_q);
endmodule

// File: rtl/dcsync_timer.sv
module dcsync_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  output logic [TIMER_W-1:0] timer_o
);
  logic [TIMER_W-1:0] timer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        timer_q <= '0;
    else if (restart_i) timer_q <= '0;
    else                timer_q <= timer_q + 1'b1;
  end

  assign timer_o = timer_q;

  p_timer_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (timer_q == '0));
endmodule

// File: rtl/dcsync_link.sv
module dcsync_link
  import dcsync_pkg::*;
#(
  parameter int TICKS       = 10,
  parameter int HI_SHORT    = 3,
  parameter int HI_LONG     = 7,
  parameter int SAMPLE_TICK = 5,
  parameter int GROUP_LEN   = 50,
  parameter int SYNC_STAGES = 2,
  parameter int TIMER_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               sync_req_i,
  output logic               line_o,
  input  logic               line_i,
  output logic               sync_o,
  output logic [TIMER_W-1:0] timer_o
);
  mode_e mode;
  logic  flag;

  assign mode = mode_e'(mode_i);

  dcsync_tx #(
    .TICKS(TICKS), .HI_SHORT(HI_SHORT), .HI_LONG(HI_LONG), .GROUP_LEN(GROUP_LEN)
  ) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .req_i(sync_req_i), .line_o(line_o)
  );

  dcsync_rx #(
    .TICKS(TICKS), .SAMPLE_TICK(SAMPLE_TICK), .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .balanced_i(mode == MODE_BALANCED),
    .line_i(line_i), .flag_o(flag)
  );

  dcsync_timer #(.TIMER_W(TIMER_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(flag), .timer_o(timer_o)
  );

  assign sync_o = flag;
endmodule

// File: tb/sim_dcsync_link.sv
module sim_dcsync_link;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        req = 1'b0;
  logic        ext_en = 1'b0;
  logic        ext_line = 1'b0;
  logic        line_o, line_i, sync_o;
  logic [15:0] timer_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign line_i = ext_en ? ext_line : line_o;

  dcsync_link u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sync_req_i(req),
    .line_o(line_o), .line_i(line_i), .sync_o(sync_o), .timer_o(timer_o)
  );

  // reference model state
  int m_tick, m_grp, m_cnt, cyc, last_rise;
  logic m_mark, m_pend, m_phase, m_line, pv, pv_vld, ef, prev_ef, last_lo;
  logic [3:0]  m_sr;
  logic [15:0] hist, m_timer;
  string ltag = "", ftag = "R6";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_tick = 9; m_grp = 0; m_cnt = 0; m_mark = 0; m_pend = 0; m_phase = 0; m_line = 0;
    m_sr = 0; hist = 0; m_timer = 0; pv = 0; pv_vld = 0; ef = 0; prev_ef = 0;
    last_lo = 0; last_rise = -1; cyc = 0;
  endtask

  task automatic model_tx(logic r);
    logic bnd, acc, ld;
    bnd = (m_tick == 9);
    acc = r && !(mode == 2'd2 && (m_pend || m_cnt != 0));
    ld  = m_pend || acc;
    if (mode != 2'd1) m_pend = ld;
    if (bnd) begin
      case (mode)
        2'd1: begin
          m_mark = m_phase;
          if (m_grp == 49) begin m_grp = 0; m_phase = !m_phase; end
          else m_grp++;
        end
        2'd2: begin
          if (m_cnt > 1) begin m_mark = m_sr[1]; m_sr = m_sr >> 1; m_cnt--; end
          else if (ld) begin m_mark = 1'b0; m_sr = 4'b0110; m_cnt = 4; m_pend = 0; end
          else begin m_mark = 1'b0; m_cnt = 0; end
        end
        default: begin m_mark = ld; m_pend = 0; end
      endcase
    end
    m_tick = bnd ? 0 : m_tick + 1;
    m_line = (m_tick < (m_mark ? 7 : 3));
  endtask

  task automatic step(logic r);
    string lt;
    req = r;
    @(posedge clk);
    model_tx(r);
    hist = {hist[14:0], (ext_en ? ext_line : m_line)};
    m_timer = prev_ef ? 16'd0 : m_timer + 16'd1;
    ef = 1'b0;
    if (hist[8] && !hist[9]) begin   // rise 8 cycles back, sample 5 ticks later
      if (mode == 2'd1) begin
        ef = pv_vld && (hist[3] != pv);
        pv = hist[3]; pv_vld = 1'b1;
      end else ef = hist[3];
    end
    prev_ef = ef;
    cyc++;
    @(negedge clk);
    lt = (ltag != "") ? ltag : (m_mark ? "R2" : "R1");
    chk(lt, "line_o", line_o, m_line);
    chk({"R4 ", ftag}, "sync_o", sync_o, ef);
    chk("R11", "timer_o", timer_o, m_timer);
    if (line_o && !last_lo) begin
      if (last_rise >= 0) chk("R3", "rise spacing", cyc - last_rise, 10);
      last_rise = cyc;
    end
    last_lo = line_o;
  endtask

  task automatic do_reset(logic [1:0] md, logic ext);
    @(negedge clk);
    rst_n = 1'b0; mode = md; ext_en = ext; ext_line = 1'b0; req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5", "reset line_o", line_o, 0);
    chk("R5", "reset sync_o", sync_o, 0);
    chk("R5", "reset timer_o", timer_o, 0);
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd13579));
    model_reset();

    // single mode: directed then random
    do_reset(2'd0, 1'b0);
    ltag = ""; ftag = "R6";
    repeat (5) step(0);
    step(1);
    repeat (30) step(0);
    step(1); step(0); step(1);             // two requests, one period
    repeat (30) step(0);
    while (m_tick != 9) step(0);
    step(1);                               // request on the last tick
    repeat (30) step(0);
    for (int i = 0; i < 600; i++) step(($urandom % 25) == 0);

    // mode 3 behaves as single
    do_reset(2'd3, 1'b0);
    repeat (8) step(0);
    step(1);
    repeat (40) step(0);

    // no flag before a rising edge on the line
    do_reset(2'd0, 1'b1);
    ftag = "R5";
    repeat (60) step(($urandom % 10) == 0);
    ext_en = 1'b0;
    repeat (60) step(($urandom % 10) == 0);

    // balanced pattern, requests ignored
    do_reset(2'd1, 1'b0);
    ltag = "R7"; ftag = "R8";
    for (int i = 0; i < 2100; i++) step(($urandom % 5) == 0);

    // couplet: directed, busy request, random
    do_reset(2'd2, 1'b0);
    ltag = "R9"; ftag = "R9";
    repeat (4) step(0);
    step(1);
    repeat (12) step(0);
    ltag = "R10";
    step(1);                               // arrives while couplet is sent
    repeat (60) step(0);
    for (int i = 0; i < 1500; i++) step(($urandom % 8) == 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule